// File: doc/BRIEF.md
# Fetch-Decode-Execute Register Processor

A small processor built around an explicit three-phase control state machine. Each instruction is fetched from a unified word memory at the address held in the instruction pointer, latched into an instruction register, and then carried out. Three working instructions exist: a three-register add, a conditional jump that branches to an absolute address when a named register holds a strictly positive signed value, and a load that copies a memory word into a register. A fourth opcode stops the machine.

The memory is an array of words with a one-hot write decoder and a read multiplexer. Its read is synchronous, so data appears one clock after the address. There are no store instructions. Memory is filled from outside through a preload write port, usually while reset is held. Any register can be inspected at any time through a combinational peek port. The `halted` output tells the environment when the program has finished.

Top module: `fde_cpu`

## Requirements
- R1: Control steps FETCH, DECODE, EXECUTE, then back to FETCH. ADD and JUMP take 3 clock cycles each. LOAD takes 4 cycles, because its execute phase waits one cycle for the synchronous memory read. HALT reaches the halted state at the end of its third cycle.
- R2: In FETCH the word at the instruction-pointer address is read, and the 8-bit pointer advances by one.
- R3: Instruction word bits [15:14] hold the opcode. Opcode 00 is ADD, with source A in [11:8], source B in [7:4] and destination in [3:0]. It writes the 8-bit sum, modulo 256, of the two source registers into the destination. A source may also be the destination.
- R4: Opcode 01 is JUMP, with the tested register in [11:8] and the target in [7:0]. When the register, read as two's complement, is greater than zero (0x01 to 0x7F), the pointer is loaded with the target.
- R5: A JUMP whose register is zero or negative (bit 7 set) is not taken, and execution continues with the next word.
- R6: Opcode 10 is LOAD, with the destination in [11:8] and the address in [7:0]. It writes bits [7:0] of the addressed word into the destination. Bits [15:8] of that word are ignored.
- R7: Opcode 11 is HALT. It stops the machine, raises `halted` and keeps it high until reset. No register changes afterwards, and no later instruction runs.
- R8: The active-low asynchronous reset clears the instruction pointer and all 16 registers to zero, drops `halted` and places control in FETCH. Memory contents survive reset.
- R9: A preload write stores one 16-bit word at exactly one address, leaves every other address unchanged, and works while reset is held.
- R10: `peek_data` shows, combinationally, the current contents of the register chosen by `peek_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload word address |
| pre_data | input | 16 | Preload word value |
| peek_sel | input | 4 | Register index to observe |
| peek_data | output | 8 | Contents of the selected register |
| halted | output | 1 | High once a HALT has executed, until reset |

## Verification
The hardest situations to reach from the ports are the jump decisions at the edges of the signed range, and a loop that ends exactly when a counter reaches zero. A register can only be given a value by loading it from preloaded memory and doing arithmetic on it. The stimulus therefore preloads programs whose data words hold 0x80, 0x01, 0xFF and a loop count. The decrement comes from adding 0xFF. Each taken or skipped jump leaves a visible trace: a register that is written only when the correct path is followed. The total cycle count from reset release to `halted` pins down the per-instruction timing, including the extra LOAD cycle.

// File: rtl/fde_pkg.sv
package fde_pkg;
  localparam int OPC_W = 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_JUMP = 2'b01,
    OP_LOAD = 2'b10,
    OP_HALT = 2'b11
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_LDWB,
    ST_HALT
  } phase_e;
endpackage

// File: rtl/fde_alu.sv
module fde_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sum,
  output logic              opa_pos
);
  assign sum     = opa + opb;
  // strictly positive in two's complement: sign clear and not zero
  assign opa_pos = ~opa[DATA_W-1] & (|opa);
endmodule

// File: rtl/fde_regfile.sv
module fde_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic [IDX_W-1:0]  ra_b,
  output logic [DATA_W-1:0] rd_b,
  input  logic [IDX_W-1:0]  ra_peek,
  output logic [DATA_W-1:0] rd_peek
);
  localparam int COUNT = 1 << IDX_W;

  logic [DATA_W-1:0] regs_q [COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COUNT; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd_a    = regs_q[ra_a];
  assign rd_b    = regs_q[ra_b];
  assign rd_peek = regs_q[ra_peek];

  // R3 R6
  reg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/fde_mem.sv
module fde_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  word_sel;
  logic [WORD_W-1:0] word_bus [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    assign word_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (word_sel[i]) word_q <= wr_data;
    end
    assign word_bus[i] = word_q;
  end

  // read multiplexer with registered output
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= word_bus[rd_addr];
  end

  always_comb begin
    // R9
    word_sel_onehot_chk: assert ($onehot0(word_sel));
  end
endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] mem_rdata,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_raddr,
  output logic [IDX_W-1:0]   ra_a,
  output logic [IDX_W-1:0]   ra_b,
  input  logic [DATA_W-1:0]  alu_sum,
  input  logic               alu_pos,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               halted
);
  localparam int SPARE_LO = 3 * IDX_W;
  localparam int SPARE_HI = INSTR_W - OPC_W - 1;

  phase_e              state_q, state_d;
  logic [ADDR_W-1:0]   ip_q, ip_d;
  logic                ip_en;
  logic [INSTR_W-1:0]  ir_q;
  logic                ir_en;

  opcode_e             opc;
  logic [IDX_W-1:0]    f_dst, f_srca, f_srcb, f_reg;
  logic [ADDR_W-1:0]   f_addr;

  assign opc    = opcode_e'(ir_q[INSTR_W-1 -: OPC_W]);
  assign f_dst  = ir_q[IDX_W-1:0];
  assign f_srcb = ir_q[2*IDX_W-1:IDX_W];
  assign f_srca = ir_q[3*IDX_W-1:2*IDX_W];
  assign f_reg  = ir_q[ADDR_W+IDX_W-1:ADDR_W];
  assign f_addr = ir_q[ADDR_W-1:0];

  if (SPARE_HI >= SPARE_LO) begin : g_spare
    logic spare_unused;
    assign spare_unused = ^ir_q[SPARE_HI:SPARE_LO];
  end

  assign ra_a   = (opc == OP_ADD) ? f_srca : f_reg;
  assign ra_b   = f_srcb;
  assign halted = (state_q == ST_HALT);

  always_comb begin
    state_d   = state_q;
    ip_d      = ip_q;
    ip_en     = 1'b0;
    ir_en     = 1'b0;
    mem_rd_en = 1'b0;
    mem_raddr = ip_q;
    rf_we     = 1'b0;
    rf_waddr  = f_dst;
    rf_wdata  = alu_sum;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        ip_d      = ip_q + 1'b1;
        ip_en     = 1'b1;
        state_d   = ST_DECODE;
      end
      ST_DECODE: begin
        ir_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (opc)
          OP_ADD: begin
            rf_we   = 1'b1;
            state_d = ST_FETCH;
          end
          OP_JUMP: begin
            ip_d    = f_addr;
            ip_en   = alu_pos;
            state_d = ST_FETCH;
          end
          OP_LOAD: begin
            mem_rd_en = 1'b1;
            mem_raddr = f_addr;
            state_d   = ST_LDWB;
          end
          OP_HALT: state_d = ST_HALT;
        endcase
      end
      ST_LDWB: begin
        rf_we    = 1'b1;
        rf_waddr = f_reg;
        rf_wdata = mem_rdata[DATA_W-1:0];
        state_d  = ST_FETCH;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ip_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ip_en) ip_q <= ip_d;
      if (ir_en) ir_q <= mem_rdata;
    end
  end

  // R1
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);
  // R1
  decode_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DECODE |=> state_q == ST_EXEC);
  // R1
  load_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && opc == OP_LOAD) |=> state_q == ST_LDWB);
  // R2
  ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> ip_q == ADDR_W'($past(ip_q) + 1'b1));
  // R4
  jump_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && opc == OP_JUMP && alu_pos) |=> ip_q == $past(f_addr));
  // R5
  jump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && opc == OP_JUMP && !alu_pos) |=> $stable(ip_q));
  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |=> (state_q == ST_HALT && !rf_we));
endmodule

// File: rtl/fde_cpu.sv
module fde_cpu #(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_we,
  input  logic [ADDR_W-1:0]  pre_addr,
  input  logic [INSTR_W-1:0] pre_data,
  input  logic [IDX_W-1:0]   peek_sel,
  output logic [DATA_W-1:0]  peek_data,
  output logic               halted
);
  logic [INSTR_W-1:0] mem_rdata;
  logic               mem_rd_en;
  logic [ADDR_W-1:0]  mem_raddr;
  logic [IDX_W-1:0]   ra_a, ra_b, rf_waddr;
  logic [DATA_W-1:0]  rd_a, rd_b, rf_wdata, alu_sum;
  logic               alu_pos, rf_we;

  fde_mem #(.WORD_W(INSTR_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (pre_we),
    .wr_addr (pre_addr),
    .wr_data (pre_data),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_raddr),
    .rd_data (mem_rdata)
  );

  fde_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_a    (ra_a),
    .rd_a    (rd_a),
    .ra_b    (ra_b),
    .rd_b    (rd_b),
    .ra_peek (peek_sel),
    .rd_peek (peek_data)
  );

  fde_alu #(.DATA_W(DATA_W)) u_alu (
    .opa     (rd_a),
    .opb     (rd_b),
    .sum     (alu_sum),
    .opa_pos (alu_pos)
  );

  fde_ctrl #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_rd_en (mem_rd_en),
    .mem_raddr (mem_raddr),
    .ra_a      (ra_a),
    .ra_b      (ra_b),
    .alu_sum   (alu_sum),
    .alu_pos   (alu_pos),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .halted    (halted)
  );
endmodule

// File: tb/tb_fde_cpu.sv
module tb_fde_cpu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_we;
  logic [7:0]  pre_addr;
  logic [15:0] pre_data;
  logic [3:0]  peek_sel;
  logic [7:0]  peek_data;
  logic        halted;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fde_cpu dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data),
    .peek_sel  (peek_sel),
    .peek_data (peek_data),
    .halted    (halted)
  );

  // expected registers: {program, index[3:0], value[7:0]}
  localparam int NVEC = 21;
  localparam logic [12:0] EXP_TBL [NVEC] = '{
    13'h0000, 13'h0100, 13'h02FF, 13'h0307, 13'h0423, 13'h055A, 13'h06FE,
    13'h070E, 13'h0805, 13'h0900, 13'h0A00, 13'h0B00, 13'h0C00, 13'h0D00,
    13'h0E00, 13'h0F00,
    13'h1080, 13'h1F02, 13'h1E00, 13'h1D7F, 13'h1C81
  };

  function automatic logic [15:0] i_add(input logic [3:0] a, input logic [3:0] b,
                                        input logic [3:0] d);
    return {2'b00, 2'b00, a, b, d};
  endfunction
  function automatic logic [15:0] i_jmp(input logic [3:0] r, input logic [7:0] t);
    return {2'b01, 2'b00, r, t};
  endfunction
  function automatic logic [15:0] i_ld(input logic [3:0] d, input logic [7:0] a);
    return {2'b10, 2'b00, d, a};
  endfunction
  function automatic logic [15:0] i_halt();
    return 16'hC000;
  endfunction

  task automatic check(input string what, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    pre_addr = a;
    pre_data = w;
    pre_we   = 1'b1;
    @(negedge clk);
    pre_we   = 1'b0;
  endtask

  task automatic run(output int cyc);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic peek(input logic [3:0] idx, output int val);
    peek_sel = idx;
    #1;
    val = peek_data;
  endtask

  task automatic walk_table(input bit prog);
    int v;
    for (int k = 0; k < NVEC; k++) begin
      if (EXP_TBL[k][12] == prog) begin
        peek(EXP_TBL[k][11:8], v);
        check($sformatf("R2 R3 R4 R5 R6 R10 prog%0d reg%0d", prog, EXP_TBL[k][11:8]),
              v, int'(EXP_TBL[k][7:0]));
      end
    end
  endtask

  initial begin
    int cyc, v;
    rst_n = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0; peek_sel = '0;
    @(negedge clk);
    // R9: preload while reset is held
    put(8'h00, i_ld(4'd1, 8'h80));
    put(8'h01, i_ld(4'd2, 8'h81));
    put(8'h02, i_ld(4'd3, 8'h82));
    put(8'h03, i_add(4'd4, 4'd3, 4'd4));
    put(8'h04, i_add(4'd1, 4'd2, 4'd1));
    put(8'h05, i_jmp(4'd1, 8'h03));
    put(8'h06, i_ld(4'd5, 8'h83));
    put(8'h07, i_add(4'd2, 4'd2, 4'd6));
    put(8'h08, i_jmp(4'd6, 8'h0C));
    put(8'h09, i_add(4'd3, 4'd3, 4'd7));
    put(8'h0A, i_jmp(4'd0, 8'h0C));
    put(8'h0B, i_add(4'd6, 4'd3, 4'd8));
    put(8'h0C, i_jmp(4'd3, 8'h0E));
    put(8'h0D, i_add(4'd3, 4'd3, 4'd9));
    put(8'h0E, i_halt());
    put(8'h0F, i_add(4'd3, 4'd3, 4'd10));
    put(8'h80, 16'h0005);
    put(8'h81, 16'h00FF);
    put(8'h82, 16'h0007);
    put(8'h83, 16'hAB5A);
    check("R8 halted low in reset", halted, 0);

    run(cyc);
    check("R1 cycles to halt, program 0", cyc, 82);
    check("R7 halted raised", halted, 1);
    walk_table(1'b0);

    repeat (20) @(negedge clk);
    check("R7 halted stays high", halted, 1);
    peek(4'd4, v);  check("R7 r4 frozen after halt", v, 8'h23);
    peek(4'd10, v); check("R7 r10 untouched after halt", v, 8'h00);

    rst_n = 1'b0;
    #1;
    check("R8 halted cleared by reset", halted, 0);
    for (int r = 0; r < 16; r++) begin
      peek(r[3:0], v);
      check($sformatf("R8 reg%0d cleared", r), v, 0);
    end

    @(negedge clk);
    put(8'h00, i_ld(4'd0, 8'h20));
    put(8'h01, i_jmp(4'd0, 8'h05));
    put(8'h02, i_ld(4'd15, 8'h21));
    put(8'h03, i_jmp(4'd15, 8'h05));
    put(8'h04, i_add(4'd15, 4'd15, 4'd14));
    put(8'h05, i_add(4'd15, 4'd15, 4'd15));
    put(8'h06, i_ld(4'd13, 8'h22));
    put(8'h07, i_add(4'd13, 4'd15, 4'd12));
    put(8'h08, i_halt());
    put(8'h20, 16'h0080);
    put(8'h21, 16'hFF01);
    put(8'h22, 16'h007F);
    run(cyc);
    check("R1 cycles to halt, program 1", cyc, 27);
    walk_table(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule